// File: doc/BRIEF.md
# Tiling Engine Interrupt Controller

This block gathers completion and stall events from a tiling graphics engine and presents them to software as pending-interrupt bits behind a small register port. Software sees one interrupt line. It reads the pending bits to find the cause and acknowledges a cause by writing a 1 to that pending bit. The block has three sources. Bin flush done and render frame done arrive as one-cycle pulses and are latched. The third source, binner memory exhausted, follows a level condition. That condition is raised by a pulse from the binner and stays active until software supplies a new overflow pool.

Enables are never written directly. A write-1 to the enable-set address turns bits on, and a write-1 to the enable-clear address turns bits off. Reading either address returns the same enable mask. While the memory-exhausted condition persists, its pending bit keeps coming back after an acknowledge. The condition is resolved by programming the overflow pool base and size. A size write retires the condition one cycle later.

Top module: `tiling_irq_ctrl`

## Requirements
- R1: After synchronous reset, all pending bits, all enable bits, the pool base, the pool size, the read data and `irq` are zero.
- R2: A write to the pending address (word 0) clears each pending bit whose data bit is 1. Data bits that are 0 leave the pending bits unchanged.
- R3: If a flush-done or frame-done pulse arrives in the same cycle as a write-1 clear of its bit, the bit stays set.
- R4: A write-1 to the enable-set address (word 1) sets those enable bits. A write-1 to the enable-clear address (word 2) clears them. Zero data bits change nothing.
- R5: A read request returns its data one clock later on `bus_rdata`. Both enable addresses return the enable mask, word 0 returns the pending bits, and words 3 and 4 return the pool base and the pool size. Bit positions are: bit 0 flush done, bit 1 frame done, bit 2 memory exhausted.
- R6: A pending bit latches even while its enable is off. `irq` is high exactly when some pending bit has its enable set, and it updates at the same edge as those bits.
- R7: An out-of-memory pulse makes the condition active at the next edge, and the pending bit 2 follows one edge later. While the condition is active, an acknowledge of bit 2 leaves it set.
- R8: Writes to words 3 and 4 load the pool base and size outputs. The condition clears on the edge after a size write, and an acknowledge after that clears bit 2.
- R9: All three pending bits can be acknowledged together with one write of 0b111.
- R10: Reads of words 5 to 7 return zero and writes to them change no state. Read-back bits above bit 2 of the pending and enable words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_flush_done | input | 1 | Bin flush done pulse |
| evt_frame_done | input | 1 | Render frame done pulse |
| evt_out_of_mem | input | 1 | Binner memory exhausted pulse |
| ovf_base | output | DATA_W | Overflow pool base address |
| ovf_size | output | DATA_W | Overflow pool size |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a source event setting a pending bit, and a software acknowledge clearing it. The bench provokes this by driving a flush-done pulse in the same cycle as a write-1 to bit 0. It also acknowledges bit 2 while the memory-exhausted condition is still active. In both cases the bit must read back as set. A behavioural reference model is updated every clock and compared against `irq`, `bus_rdata` and the pool outputs. Directed checks then read back the exact pending and enable words expected at each step.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_FLUSH = 0;
  localparam int SRC_FRAME = 1;
  localparam int SRC_OOM   = 2;

  localparam int ADR_PEND   = 0;
  localparam int ADR_EN_SET = 1;
  localparam int ADR_EN_CLR = 2;
  localparam int ADR_BASE   = 3;
  localparam int ADR_SIZE   = 4;

  typedef enum logic [2:0] {
    SEL_PEND,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_BASE,
    SEL_SIZE,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/tic_decode.sv
module tic_decode
  import tic_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wbits,
  output reg_sel_e          sel,
  output logic              rd_en,
  output logic [NSRC-1:0]   ack_mask,
  output logic [NSRC-1:0]   set_mask,
  output logic [NSRC-1:0]   dis_mask,
  output logic              base_we,
  output logic              size_we
);
  logic wr_en;

  always_comb begin
    if      (addr == ADDR_W'(ADR_PEND))   sel = SEL_PEND;
    else if (addr == ADDR_W'(ADR_EN_SET)) sel = SEL_EN_SET;
    else if (addr == ADDR_W'(ADR_EN_CLR)) sel = SEL_EN_CLR;
    else if (addr == ADDR_W'(ADR_BASE))   sel = SEL_BASE;
    else if (addr == ADDR_W'(ADR_SIZE))   sel = SEL_SIZE;
    else                                  sel = SEL_NONE;
  end

  assign wr_en    = valid && write;
  assign rd_en    = valid && !write;
  assign ack_mask = (wr_en && sel == SEL_PEND)   ? wbits : '0;
  assign set_mask = (wr_en && sel == SEL_EN_SET) ? wbits : '0;
  assign dis_mask = (wr_en && sel == SEL_EN_CLR) ? wbits : '0;
  assign base_we  = wr_en && sel == SEL_BASE;
  assign size_we  = wr_en && sel == SEL_SIZE;
endmodule

// File: rtl/tic_pend_bank.sv
module tic_pend_bank #(
  parameter int              NSRC       = 3,
  parameter logic [NSRC-1:0] LEVEL_MASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] pend_d
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // a source event overrides an acknowledge in the same cycle
    assign pend_d[i] = (pend_q[i] & ~clr[i]) | evt[i];

    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_d[i];
    end

    p_ack_clears_r2: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !evt[i]) |=> !pend_q[i]);

    if (LEVEL_MASK[i]) begin : g_level
      p_level_reasserts_r7: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> pend_q[i]);
    end else begin : g_pulse
      p_event_wins_r3: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> pend_q[i]);
    end
  end
endmodule

// File: rtl/tic_enable_mask.sv
module tic_enable_mask #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_mask,
  input  logic [NSRC-1:0] dis_mask,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] en_d
);
  assign en_d = (en_q | set_mask) & ~dis_mask;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    p_enable_set_r4: assert property (@(posedge clk) disable iff (rst)
      (set_mask[i] && !dis_mask[i]) |=> en_q[i]);
    p_enable_clear_r4: assert property (@(posedge clk) disable iff (rst)
      dis_mask[i] |=> !en_q[i]);
    p_enable_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!set_mask[i] && !dis_mask[i]) |=> $stable(en_q[i]));
  end
endmodule

// File: rtl/tic_ovf_pool.sv
module tic_ovf_pool #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic              size_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oom_pulse,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] size_q,
  output logic              cond_q
);
  logic resolve_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      size_q    <= '0;
      resolve_q <= 1'b0;
      cond_q    <= 1'b0;
    end else begin
      if (base_we) base_q <= wdata;
      if (size_we) size_q <= wdata;
      resolve_q <= size_we;
      cond_q    <= (cond_q & ~resolve_q) | oom_pulse;
    end
  end

  p_oom_raise_r7: assert property (@(posedge clk) disable iff (rst)
    oom_pulse |=> cond_q);
  p_oom_resolve_r8: assert property (@(posedge clk) disable iff (rst)
    (resolve_q && !oom_pulse) |=> !cond_q);
  p_size_load_r8: assert property (@(posedge clk) disable iff (rst)
    size_we |=> (size_q == $past(wdata)));
  p_base_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !base_we |=> $stable(base_q));
endmodule

// File: rtl/tiling_irq_ctrl.sv
module tiling_irq_ctrl
  import tic_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_flush_done,
  input  logic              evt_frame_done,
  input  logic              evt_out_of_mem,
  output logic [DATA_W-1:0] ovf_base,
  output logic [DATA_W-1:0] ovf_size,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NSRC;
  localparam logic [NSRC-1:0] LEVEL_SRCS = NSRC'(1) << SRC_OOM;

  reg_sel_e        sel;
  logic            rd_en, base_we, size_we, oom_cond;
  logic [NSRC-1:0] ack_mask, set_mask, dis_mask;
  logic [NSRC-1:0] pend_q, pend_d, en_q, en_d, evt_vec;
  logic [DATA_W-1:0] rd_next;

  tic_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .wbits(bus_wdata[NSRC-1:0]), .sel(sel), .rd_en(rd_en),
    .ack_mask(ack_mask), .set_mask(set_mask), .dis_mask(dis_mask),
    .base_we(base_we), .size_we(size_we)
  );

  tic_ovf_pool #(.DATA_W(DATA_W)) u_pool (
    .clk(clk), .rst(rst), .base_we(base_we), .size_we(size_we),
    .wdata(bus_wdata), .oom_pulse(evt_out_of_mem),
    .base_q(ovf_base), .size_q(ovf_size), .cond_q(oom_cond)
  );

  always_comb begin
    evt_vec            = '0;
    evt_vec[SRC_FLUSH] = evt_flush_done;
    evt_vec[SRC_FRAME] = evt_frame_done;
    evt_vec[SRC_OOM]   = oom_cond;
  end

  tic_pend_bank #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_SRCS)) u_pend (
    .clk(clk), .rst(rst), .evt(evt_vec), .clr(ack_mask),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  tic_enable_mask #(.NSRC(NSRC)) u_enable (
    .clk(clk), .rst(rst), .set_mask(set_mask), .dis_mask(dis_mask),
    .en_q(en_q), .en_d(en_d)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND:              rd_next = {{PAD_W{1'b0}}, pend_q};
      SEL_EN_SET, SEL_EN_CLR: rd_next = {{PAD_W{1'b0}}, en_q};
      SEL_BASE:              rd_next = ovf_base;
      SEL_SIZE:              rd_next = ovf_size;
      default:               rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd_en) bus_rdata <= rd_next;
      irq <= |(pend_d & en_d);
    end
  end

  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|en_q));
  p_irq_needs_pending_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|pend_q));
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/test_tiling_irq_ctrl.sv
module test_tiling_irq_ctrl;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata, ovf_base, ovf_size;
  logic evt_flush_done = 1'b0, evt_frame_done = 1'b0, evt_out_of_mem = 1'b0;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tiling_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tiling_irq_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_flush_done(evt_flush_done), .evt_frame_done(evt_frame_done),
    .evt_out_of_mem(evt_out_of_mem), .ovf_base(ovf_base),
    .ovf_size(ovf_size), .irq(irq)
  );

  // behavioural reference model
  bit [2:0]  m_pend, m_en;
  bit        m_cond, m_resolve, m_irq;
  bit [31:0] m_base, m_size, m_rd;

  always @(posedge clk) begin
    bit [2:0] np, ne, w3;
    bit       nc;
    if (rst) begin
      m_pend = 0; m_en = 0; m_cond = 0; m_resolve = 0;
      m_irq = 0; m_base = 0; m_size = 0; m_rd = 0;
    end else begin
      w3 = bus_wdata[2:0];
      if (bus_valid && !bus_write) begin
        case (bus_addr)
          3'd0: m_rd = {29'd0, m_pend};
          3'd1, 3'd2: m_rd = {29'd0, m_en};
          3'd3: m_rd = m_base;
          3'd4: m_rd = m_size;
          default: m_rd = 0;
        endcase
      end
      np = m_pend;
      ne = m_en;
      if (bus_valid && bus_write && bus_addr == 3'd0) np = np & ~w3;
      if (bus_valid && bus_write && bus_addr == 3'd1) ne = ne | w3;
      if (bus_valid && bus_write && bus_addr == 3'd2) ne = ne & ~w3;
      if (evt_flush_done) np[0] = 1'b1;
      if (evt_frame_done) np[1] = 1'b1;
      if (m_cond)         np[2] = 1'b1;
      nc = (m_cond && !m_resolve) || evt_out_of_mem;
      m_resolve = bus_valid && bus_write && bus_addr == 3'd4;
      if (bus_valid && bus_write && bus_addr == 3'd3) m_base = bus_wdata;
      if (bus_valid && bus_write && bus_addr == 3'd4) m_size = bus_wdata;
      m_cond = nc;
      m_pend = np;
      m_en = ne;
      m_irq = |(np & ne);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(irq === m_irq, "R6 model irq", {31'd0, irq}, {31'd0, m_irq});
      check(bus_rdata === m_rd, "R5 model rdata", bus_rdata, m_rd);
      check(ovf_base === m_base, "R8 model base", ovf_base, m_base);
      check(ovf_size === m_size, "R8 model size", ovf_size, m_size);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wdata = '0;
  endtask

  task automatic rd(input int a);
    bus_valid = 1; bus_write = 0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd_expect(input int a, input logic [31:0] exp, input string req);
    rd(a);
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    check(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);
    check(ovf_base === 0, "R1 base", ovf_base, 0);
    check(ovf_size === 0, "R1 size", ovf_size, 0);
    for (int a = 0; a < 5; a++) rd_expect(a, 0, "R1 readback");

    // R4: enable set / clear, zeros ignored
    wr(1, 32'h7);
    rd_expect(2, 32'h7, "R4 set all, read via clear address");
    wr(2, 32'h2);
    rd_expect(1, 32'h5, "R4 clear bit1");
    wr(1, 32'h0);
    rd_expect(2, 32'h5, "R4 zero write ignored");
    wr(2, 32'h0);
    rd_expect(1, 32'h5, "R4 zero disable ignored");
    wr(1, 32'h2);

    // R6: flush pulse raises irq
    evt_flush_done = 1; @(negedge clk); evt_flush_done = 0;
    check(irq === 1'b1, "R6 irq after flush", {31'd0, irq}, 1);
    rd_expect(0, 32'h1, "R5 pending flush bit0");
    wr(0, 32'h0);
    rd_expect(0, 32'h1, "R2 zero ack keeps bit");
    wr(2, 32'h1);
    check(irq === 1'b0, "R6 disabled masks irq", {31'd0, irq}, 0);
    rd_expect(0, 32'h1, "R6 pending latched while disabled");

    // R3: event and acknowledge in the same cycle
    evt_flush_done = 1; wr(0, 32'h1); evt_flush_done = 0;
    rd_expect(0, 32'h1, "R3 event wins over ack");
    wr(0, 32'h1);
    rd_expect(0, 32'h0, "R2 ack clears flush");

    // frame done with enable on
    evt_frame_done = 1; @(negedge clk); evt_frame_done = 0;
    check(irq === 1'b1, "R6 irq after frame", {31'd0, irq}, 1);
    wr(0, 32'h2);
    check(irq === 1'b0, "R2 ack frame drops irq", {31'd0, irq}, 0);
    rd_expect(0, 32'h0, "R2 frame cleared");

    // R7 / R8: memory exhausted level source
    evt_out_of_mem = 1; @(negedge clk); evt_out_of_mem = 0;
    idle(1);
    rd_expect(0, 32'h4, "R7 oom pending");
    check(irq === 1'b1, "R7 oom irq", {31'd0, irq}, 1);
    wr(0, 32'h4);
    rd_expect(0, 32'h4, "R7 ack while condition persists");
    wr(3, 32'h0001_0000);
    wr(4, 32'h0000_0800);
    check(ovf_base === 32'h0001_0000, "R8 base out", ovf_base, 32'h0001_0000);
    check(ovf_size === 32'h0000_0800, "R8 size out", ovf_size, 32'h0000_0800);
    idle(1);
    wr(0, 32'h4);
    rd_expect(0, 32'h0, "R8 ack after resolve");
    check(irq === 1'b0, "R8 irq low after resolve", {31'd0, irq}, 0);
    rd_expect(3, 32'h0001_0000, "R5 base readback");
    rd_expect(4, 32'h0000_0800, "R5 size readback");

    // R9: combined acknowledge
    evt_flush_done = 1; evt_frame_done = 1; evt_out_of_mem = 1;
    @(negedge clk);
    evt_flush_done = 0; evt_frame_done = 0; evt_out_of_mem = 0;
    idle(1);
    rd_expect(0, 32'h7, "R9 all three pending");
    wr(4, 32'h0000_0400);
    idle(1);
    wr(0, 32'h7);
    rd_expect(0, 32'h0, "R9 combined ack");

    // R10: unused addresses and upper bits
    wr(5, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    rd_expect(5, 32'h0, "R10 unused read zero");
    rd_expect(1, 32'h6, "R10 enable word upper bits zero");
    rd_expect(0, 32'h0, "R10 unused write no effect");
    check(ovf_size === 32'h0000_0400, "R10 size untouched", ovf_size, 32'h0000_0400);

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule